// File: doc/BRIEF.md
# Main Clock Loss Detector with On-Chip Oscillator Failover

This block runs on a free-running on-chip reference clock and watches the main clock. It passes the main clock through a two-flop synchronizer and looks for its rising edges. If it sees no edge for a programmable number of reference cycles, it declares the main clock stopped. It then does four things in a single cycle: it moves the system clock select to the on-chip oscillator, sets a sticky "main clock stopped" flag, clears the low-speed oscillator off control so that oscillator runs, and raises an interrupt request.

The block only checks while two conditions hold: its 2-bit enable field holds the code 11b, and the main clock is the selected source. After a failover it cannot fire again until software selects the main clock once more. It never returns to the main clock on its own. A separate register bit tells the clock logic which on-chip oscillator to use, low-speed or high-speed. The interrupt line is shared with a watchdog and a voltage monitor. Each of the three causes has its own readable flag.

The block outputs only select and control levels. The oscillators and the glitch-free clock multiplexer are outside it. Detection is meant for main clocks of 2 MHz and above, with the timeout sized to the reference clock.

Top module: `osc_fail_guard`

## Requirements
- R1: Detection runs only while the enable field (CTRL bits [1:0]) equals 11b. With 00b, 01b or 10b, a stopped main clock changes no state and raises no interrupt.
- R2: While armed, if no synchronized rising edge of `main_clk` arrives for LIMIT reference cycles, `clk_sel_onchip` and CTRL bit 2 go to 1.
- R3: The same detection event does three more things: it sets the main-stopped flag (CTRL bit 3), clears the low-speed-off control (CTRL bit 5, output `lso_off`) to 0, and sets the oscillator-stop flag (IRQ register, address 2, bit 0).
- R4: `irq` is the OR of the oscillator-stop flag, `wdt_flag` and `vmon_flag`. The IRQ register reads bit 0 = oscillator stop, bit 1 = watchdog, bit 2 = voltage monitor.
- R5: CTRL bit 4 selects the on-chip oscillator for failover: 0 = low-speed, 1 = high-speed. It drives `onchip_hs`.
- R6: The hardware never clears `clk_sel_onchip`. Only a write to CTRL with bit 2 = 0 returns the select to the main clock.
- R7: The main-stopped flag and the oscillator-stop flag clear only when software writes 0 to them (CTRL bit 3; IRQ bit 0). Writing 1 to either has no effect.
- R8: While `clk_sel_onchip` is 1, detection is off, even if the enable field is 11b and the main clock has stopped.
- R9: A main clock that keeps toggling with edges closer together than LIMIT reference cycles never triggers detection. LIMIT is held in the register at address 1, bits [7:0].
- R10: Reset values: enable 00b, select 0, main-stopped 0, high-speed choice 0, low-speed-off 1 (CTRL reads 0x20), LIMIT 8, IRQ flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running on-chip reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_clk | input | 1 | Main clock under watch (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 CTRL, 1 LIMIT, 2 IRQ |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| wdt_flag | input | 1 | Watchdog interrupt flag |
| vmon_flag | input | 1 | Voltage monitor interrupt flag |
| clk_sel_onchip | output | 1 | 1 selects the on-chip oscillator as system clock |
| onchip_hs | output | 1 | On-chip oscillator choice: 0 low-speed, 1 high-speed |
| lso_off | output | 1 | 1 keeps the low-speed oscillator stopped |
| irq | output | 1 | Shared interrupt request |

## Verification
A stuck or miscounted edge counter shows up within one timeout window at the ports. It appears either as a failover while the main clock still toggles, or as no failover a few cycles after LIMIT has passed. A wrong arming term shows as `clk_sel_onchip` rising while the enable field is not 11b, or as the flags being set again after a failover. A bad flag update shows in the next register read: a flag that clears without a write of 0, or `lso_off` and the IRQ bit not matching the select in the cycle after detection.

// File: rtl/osg_pkg.sv
`timescale 1ns/1ps
package osg_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_LIMIT = 2'd1,
        ADDR_IRQ   = 2'd2
    } reg_addr_e;

    // CTRL bit positions
    localparam int unsigned CTRL_EN_LO   = 0;
    localparam int unsigned CTRL_ONCHIP  = 2;
    localparam int unsigned CTRL_STOPPED = 3;
    localparam int unsigned CTRL_HS      = 4;
    localparam int unsigned CTRL_LSO_OFF = 5;
    localparam int unsigned CTRL_BITS    = 6;

    // IRQ register bit positions
    localparam int unsigned IRQ_OSC  = 0;
    localparam int unsigned IRQ_WDT  = 1;
    localparam int unsigned IRQ_VMON = 2;
    localparam int unsigned IRQ_BITS = 3;

    localparam logic [1:0] DET_ON = 2'b11;

    typedef struct packed {
        logic [1:0] en;
        logic       onchip;
        logic       stopped;
        logic       hs;
        logic       lso_off;
    } ctrl_t;

endpackage

// File: rtl/osg_sync.sv
`timescale 1ns/1ps
module osg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
        st_d.prev  = st_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[LAST] & ~st_q.prev;

    initial begin
        AST_SYNC_DEPTH: assert (STAGES >= 2); // R9
    end

    // A rise pulse lasts one cycle: the next cycle's prev equals this cycle's last stage
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R9

endmodule

// File: rtl/osg_timer.sv
`timescale 1ns/1ps
module osg_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W:0] elapsed_ext;
    logic           window_done;

    always_comb begin
        elapsed_ext = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        window_done = (elapsed_ext >= {1'b0, limit_i});
        expire_o    = armed_i && !rise_i && window_done;

        st_d = st_q;
        if (!armed_i || rise_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_RISE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> (st_q.cnt == '0)); // R9

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |=> (st_q.cnt == '0)); // R8

endmodule

// File: rtl/osg_regs.sv
`timescale 1ns/1ps
module osg_regs
    import osg_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned CNT_DEF = 8,
    parameter int unsigned DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              expire_i,
    input  logic              wdt_flag_i,
    input  logic              vmon_flag_i,
    output logic              armed_o,
    output logic [CNT_W-1:0]  limit_o,
    output logic              onchip_o,
    output logic              hs_o,
    output logic              lso_off_o,
    output logic              irq_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] limit;
        logic             osc_irq;
    } reg_state_t;

    localparam reg_state_t RST_VAL = '{
        ctrl:    '{en: 2'b00, onchip: 1'b0, stopped: 1'b0, hs: 1'b0, lso_off: 1'b1},
        limit:   CNT_W'(CNT_DEF),
        osc_irq: 1'b0
    };

    reg_state_t st_d, st_q;
    reg_addr_e  addr_e;
    logic       ctrl_wr, limit_wr, irq_wr;
    logic       wdata_unused;

    assign addr_e       = reg_addr_e'(addr_i);
    assign ctrl_wr      = wr_i && (addr_e == ADDR_CTRL);
    assign limit_wr     = wr_i && (addr_e == ADDR_LIMIT);
    assign irq_wr       = wr_i && (addr_e == ADDR_IRQ);
    assign wdata_unused = ^wdata_i;

    always_comb begin
        st_d = st_q;

        if (ctrl_wr) begin
            st_d.ctrl.en      = wdata_i[CTRL_EN_LO +: 2];
            st_d.ctrl.onchip  = wdata_i[CTRL_ONCHIP];
            st_d.ctrl.hs      = wdata_i[CTRL_HS];
            st_d.ctrl.lso_off = wdata_i[CTRL_LSO_OFF];
            if (!wdata_i[CTRL_STOPPED]) st_d.ctrl.stopped = 1'b0;
        end
        if (limit_wr) begin
            st_d.limit = wdata_i[CNT_W-1:0];
        end
        if (irq_wr && !wdata_i[IRQ_OSC]) begin
            st_d.osc_irq = 1'b0;
        end

        // detection has priority over a write in the same cycle
        if (expire_i) begin
            st_d.ctrl.onchip  = 1'b1;
            st_d.ctrl.stopped = 1'b1;
            st_d.ctrl.lso_off = 1'b0;
            st_d.osc_irq      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_e)
            ADDR_CTRL:  rdata_o = DATA_W'({st_q.ctrl.lso_off, st_q.ctrl.hs, st_q.ctrl.stopped,
                                           st_q.ctrl.onchip, st_q.ctrl.en});
            ADDR_LIMIT: rdata_o = DATA_W'(st_q.limit);
            ADDR_IRQ:   rdata_o = DATA_W'({vmon_flag_i, wdt_flag_i, st_q.osc_irq});
            default:    rdata_o = '0;
        endcase
    end

    assign armed_o   = (st_q.ctrl.en == DET_ON) && !st_q.ctrl.onchip;
    assign limit_o   = st_q.limit;
    assign onchip_o  = st_q.ctrl.onchip;
    assign hs_o      = st_q.ctrl.hs;
    assign lso_off_o = st_q.ctrl.lso_off;
    assign irq_o     = st_q.osc_irq | wdt_flag_i | vmon_flag_i;

    initial begin
        AST_WIDTH_FIT: assert (DATA_W >= CTRL_BITS && DATA_W >= CNT_W && DATA_W >= IRQ_BITS); // R10
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en != DET_ON) |-> !expire_i); // R1

    AST_FAILOVER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> st_q.ctrl.onchip); // R2

    AST_FAILOVER_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> (st_q.ctrl.stopped && !st_q.ctrl.lso_off && st_q.osc_irq)); // R3

    AST_NO_SELF_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.onchip && !ctrl_wr) |=> st_q.ctrl.onchip); // R6

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.stopped && !(ctrl_wr && !wdata_i[CTRL_STOPPED])) |=> st_q.ctrl.stopped); // R7

    AST_OSC_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.osc_irq && !(irq_wr && !wdata_i[IRQ_OSC])) |=> st_q.osc_irq); // R7

    AST_ONCHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.onchip |-> !expire_i); // R8

endmodule

// File: rtl/osc_fail_guard.sv
`timescale 1ns/1ps
module osc_fail_guard #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned CNT_DEF     = 8,
    parameter int unsigned DATA_W      = 8
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              main_clk,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wdt_flag,
    input  logic              vmon_flag,
    output logic              clk_sel_onchip,
    output logic              onchip_hs,
    output logic              lso_off,
    output logic              irq
);
    logic             main_rise;
    logic             armed;
    logic             expire;
    logic [CNT_W-1:0] limit;

    osg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .async_i (main_clk),
        .rise_o  (main_rise)
    );

    osg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .armed_i  (armed),
        .rise_i   (main_rise),
        .limit_i  (limit),
        .expire_o (expire)
    );

    osg_regs #(.CNT_W(CNT_W), .CNT_DEF(CNT_DEF), .DATA_W(DATA_W)) u_regs (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .wr_i        (reg_wr),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .rdata_o     (reg_rdata),
        .expire_i    (expire),
        .wdt_flag_i  (wdt_flag),
        .vmon_flag_i (vmon_flag),
        .armed_o     (armed),
        .limit_o     (limit),
        .onchip_o    (clk_sel_onchip),
        .hs_o        (onchip_hs),
        .lso_off_o   (lso_off),
        .irq_o       (irq)
    );

    // Failover and the low-speed run control move together
    AST_SELECT_WITH_LSO: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(clk_sel_onchip) && !$past(reg_wr) |-> !lso_off); // R3

endmodule

// File: tb/sim_osc_fail_guard.sv
`timescale 1ns/1ps
module sim_osc_fail_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_clk = 1'b0;
    logic       main_run = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       wdt_flag = 1'b0;
    logic       vmon_flag = 1'b0;
    logic       clk_sel_onchip, onchip_hs, lso_off, irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    // main clock: 16 ns period, held low while stopped
    always begin
        if (main_run) begin
            #8;
            if (main_run) main_clk = ~main_clk;
            else          main_clk = 1'b0;
        end else begin
            main_clk = 1'b0;
            wait (main_run);
        end
    end

    osc_fail_guard u0 (
        .clk_ref        (clk),
        .rst_n          (rst_n),
        .main_clk       (main_clk),
        .reg_wr         (reg_wr),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .wdt_flag       (wdt_flag),
        .vmon_flag      (vmon_flag),
        .clk_sel_onchip (clk_sel_onchip),
        .onchip_hs      (onchip_hs),
        .lso_off        (lso_off),
        .irq            (irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [7:0] ctrl_word(logic [1:0] en, logic sel, logic stp,
                                             logic hs, logic lso);
        return {2'b00, lso, hs, stp, sel, en};
    endfunction

    function automatic logic expect_switch(logic [1:0] en);
        return en == 2'b11;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    logic [7:0] rv;

    initial begin
        void'($urandom(32'd4711));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R10 reset state
        rd(2'd0, rv); chk("R10 ctrl reset", rv, 8'h20);
        rd(2'd1, rv); chk("R10 limit reset", rv, 8);
        rd(2'd2, rv); chk("R10 irq reg reset", rv, 0);
        chk("R10 select reset", clk_sel_onchip, 0);
        chk("R10 lso_off reset", lso_off, 1);
        chk("R10 irq reset", irq, 0);

        // R1 disabled codes with a stopped main clock
        for (int e = 0; e < 3; e++) begin
            wr(2'd0, ctrl_word(2'(e), 1'b0, 1'b0, 1'b0, 1'b1));
            wait_cyc(40);
            chk("R1 no failover when disabled", clk_sel_onchip, 0);
            rd(2'd0, rv); chk("R1 ctrl untouched", rv, ctrl_word(2'(e), 0, 0, 0, 1));
            chk("R1 no irq when disabled", irq, 0);
        end

        // R9 running clock, default limit
        main_run = 1'b1;
        wait_cyc(6);
        wr(2'd0, ctrl_word(2'b11, 1'b0, 1'b0, 1'b0, 1'b1));
        wait_cyc(200);
        chk("R9 running clock never trips", clk_sel_onchip, 0);

        // R2/R3 stop at default limit 8
        main_run = 1'b0;
        wait_cyc(4);
        chk("R2 not before limit", clk_sel_onchip, 0);
        wait_cyc(9);
        chk("R2 failover select", clk_sel_onchip, 1);
        rd(2'd0, rv); chk("R3 ctrl after detect", rv, ctrl_word(2'b11, 1, 1, 0, 0));
        chk("R3 lso_off cleared", lso_off, 0);
        rd(2'd2, rv); chk("R3 osc flag set", rv, 1);
        chk("R4 irq raised", irq, 1);

        // R6/R8 main restarts: no return, no re-trigger
        main_run = 1'b1;
        wait_cyc(50);
        chk("R6 no automatic return", clk_sel_onchip, 1);
        wr(2'd0, ctrl_word(2'b11, 1'b1, 1'b0, 1'b0, 1'b0));
        main_run = 1'b0;
        wait_cyc(40);
        rd(2'd0, rv); chk("R8 no re-detect while on-chip", rv, ctrl_word(2'b11, 1, 0, 0, 0));

        // R7 write 1 to cleared stopped flag has no effect
        wr(2'd0, ctrl_word(2'b11, 1'b1, 1'b1, 1'b0, 1'b0));
        rd(2'd0, rv); chk("R7 write 1 to stopped ignored", rv[3], 0);
        rd(2'd2, rv); chk("R7 osc flag still set", rv[0], 1);
        wr(2'd2, 8'h01);
        rd(2'd2, rv); chk("R7 write 1 to osc flag keeps it", rv[0], 1);
        wr(2'd2, 8'h00);
        rd(2'd2, rv); chk("R7 osc flag cleared by 0", rv[0], 0);
        chk("R7 irq low after clear", irq, 0);
        wr(2'd2, 8'h01);
        rd(2'd2, rv); chk("R7 write 1 does not set flag", rv[0], 0);

        // R6 software return
        main_run = 1'b1;
        wait_cyc(6);
        wr(2'd0, ctrl_word(2'b11, 1'b0, 1'b0, 1'b0, 1'b1));
        chk("R6 software return", clk_sel_onchip, 0);

        // R5 oscillator choice
        wr(2'd0, ctrl_word(2'b11, 1'b0, 1'b0, 1'b1, 1'b1));
        chk("R5 high-speed choice", onchip_hs, 1);
        wr(2'd0, ctrl_word(2'b11, 1'b0, 1'b0, 1'b0, 1'b1));
        chk("R5 low-speed choice", onchip_hs, 0);

        // R4 shared irq sources
        for (int i = 0; i < 4; i++) begin
            wdt_flag = i[0]; vmon_flag = i[1];
            rd(2'd2, rv);
            chk("R4 irq source flags", rv, {5'b0, vmon_flag, wdt_flag, 1'b0});
            chk("R4 irq or", irq, int'(wdt_flag | vmon_flag));
        end
        wdt_flag = 1'b0; vmon_flag = 1'b0;

        // random: enable code, limit, hs choice
        for (int it = 0; it < 30; it++) begin
            logic [1:0] en;
            logic       hs;
            int         lim;
            int         run;
            en  = 2'($urandom % 4);
            hs  = 1'($urandom % 2);
            lim = 6 + int'($urandom % 15);
            run = 20 + int'($urandom % 60);
            main_run = 1'b1;
            wait_cyc(6);
            wr(2'd1, 8'(lim));
            wr(2'd0, ctrl_word(en, 1'b0, 1'b0, hs, 1'b1));
            wr(2'd2, 8'h00);
            wait_cyc(run);
            chk("R9 random running", clk_sel_onchip, 0);
            main_run = 1'b0;
            wait_cyc(lim - 4);
            chk("R2 random early", clk_sel_onchip, 0);
            wait_cyc(9);
            chk("R1 random switch", clk_sel_onchip, int'(expect_switch(en)));
            rd(2'd0, rv);
            chk("R3 random ctrl", rv, expect_switch(en) ? ctrl_word(en, 1, 1, hs, 0)
                                                         : ctrl_word(en, 0, 0, hs, 1));
            chk("R5 random choice", onchip_hs, hs);
            chk("R4 random irq", irq, int'(expect_switch(en)));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule